// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small up-counter. It moves only on the rising clock edge. It can be preset from a parallel data input, cleared by an active-low clear, and chained with other instances of itself into a counter of any width without ripple. Two enables control counting, and both must be high for the state to advance. One of them, the chain enable, also qualifies a combinational terminal-count flag. That flag goes high when the state sits at its top value. In a chain, every stage takes a common enable on its first enable input. Each stage feeds its terminal count into the chain enable of the next stage.

Two parameters choose the variant. The first picks whether the clear acts at once, independent of the clock, or only at a rising edge. The second picks a binary count (0 to 2^WIDTH-1) or a decade count (0 to 9). In decade mode, a state above 9 can appear after a preset or at power-up. Any such state returns to 0 on the next count.

Top module: `presettable_counter`

## Requirements
- R1: With `ASYNC_CLR`=0, a low `clr_n` sampled at a rising edge sets `q` to 0 at that edge, and `q` does not change between edges.
- R2: With `ASYNC_CLR`=1, `q` becomes 0 as soon as `clr_n` goes low, with no clock edge needed.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`. This happens whatever the levels of `cnt_en` and `chain_en`.
- R4: In binary mode, when `clr_n`, `load_n`, `cnt_en` and `chain_en` are all high at a rising edge, `q` increments by one. From 2^WIDTH-1 it wraps to 0.
- R5: When `clr_n` and `load_n` are high and either `cnt_en` or `chain_en` is low, `q` holds its value.
- R6: A low `clr_n` wins over a low `load_n` and over both enables.
- R7: `term` equals `chain_en` AND (`q` equal to the top count). It does not depend on `cnt_en`. The top count is 2^WIDTH-1 in binary mode and 9 in decade mode.
- R8: In decade mode, counting runs 0, 1, …, 9 and then back to 0.
- R9: In decade mode, a count from any state from 10 to 15 gives 0.
- R10: Stages chained through `term` into the next stage's `chain_en`, with a common `cnt_en`, count together as one wider binary counter, and the last stage's `term` marks the overall top count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel preset strobe |
| din | input | WIDTH | Preset value |
| cnt_en | input | 1 | Count enable that does not affect `term` |
| chain_en | input | 1 | Count enable that also qualifies `term` |
| q | output | WIDTH | Counter state |
| term | output | 1 | Terminal-count flag |

## Verification
The clocked properties are switched off while `clr_n` is low. They assume that `clr_n`, `load_n`, the enables and `din` are stable around each rising edge. The stimulus therefore changes every input on the falling edge. The only exception is the check for an immediate clear, which drops `clr_n` mid-cycle and samples the state before the next edge. The decade instance is preset to every value from 10 to 15, so that recovery from out-of-range states is checked from inputs the block legally accepts.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;

  function automatic int top_count(input int width, input bit decade);
    return decade ? 9 : (1 << width) - 1;
  endfunction
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output cnt_op_e op
);
  // load outranks counting; clear is handled in the state register
  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_COUNT;
    else                        op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  cnt_op_e          op,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(top_count(WIDTH, DECADE));

  // any state at or above the top count folds to zero in one count
  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = (q >= MAX_CNT) ? '0 : q + WIDTH'(1);
      default:  nxt = q;
    endcase
  end
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term.sv
module cnt_term
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en,
  output logic             term
);
  localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(top_count(WIDTH, DECADE));

  assign term = chain_en && (q == MAX_CNT);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0,
  parameter bit DECADE    = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] q,
  output logic             term
);
  localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(top_count(WIDTH, DECADE));

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl u_ctrl (
    .load_n  (load_n),
    .cnt_en  (cnt_en),
    .chain_en(chain_en),
    .op      (op)
  );

  cnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .q  (q),
    .din(din),
    .op (op),
    .nxt(nxt)
  );

  cnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk  (clk),
    .clr_n(clr_n),
    .nxt  (nxt),
    .q    (q)
  );

  cnt_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .q       (q),
    .chain_en(chain_en),
    .term    (term)
  );

  // clear beats everything: state is zero the cycle after a low clear (R1, R6)
  p_clear_r1: assert property (@(posedge clk) !clr_n |=> (q == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(din)));

  p_count_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en && (q < MAX_CNT)) |=> (q == $past(q) + WIDTH'(1)));

  // wrap at the top and recovery from out-of-range states (R8, R9)
  p_wrap_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en && (q >= MAX_CNT)) |=> (q == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(q));

  p_term_chain_r7: assert property (@(posedge clk) disable iff (!clr_n)
    term |-> chain_en);

  p_term_top_r7: assert property (@(posedge clk) disable iff (!clr_n)
    term |-> (q == MAX_CNT));
endmodule

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        clr_n = 1'b0, load_n = 1'b1, enp = 1'b0, ent = 1'b0;
  logic [3:0]  din = '0;
  logic        cen = 1'b0, cload_n = 1'b1;
  logic [11:0] cdin = '0;

  logic [3:0]  q_bin, q_dec, q_asy;
  logic        tc_bin, tc_dec, tc_asy;
  logic [11:0] cq;
  logic [2:0]  ctc;
  logic [2:0]  cchain;

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .cnt_en(enp), .chain_en(ent), .q(q_bin), .term(tc_bin));

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b1)) u_dec (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .cnt_en(enp), .chain_en(ent), .q(q_dec), .term(tc_dec));

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b0)) u_asy (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .cnt_en(enp), .chain_en(ent), .q(q_asy), .term(tc_asy));

  // R10: three stages chained through the terminal count
  assign cchain = {ctc[1:0], cen};
  for (genvar i = 0; i < 3; i++) begin : g_stage
    presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) u_stage (
      .clk(clk), .clr_n(clr_n), .load_n(cload_n), .din(cdin[4*i +: 4]),
      .cnt_en(cen), .chain_en(cchain[i]), .q(cq[4*i +: 4]), .term(ctc[i]));
  end

  typedef struct {
    string tag;
    int    unit;
    int    exp_q;
    bit    exp_tc;
  } item_t;

  item_t sbq[$];
  int    m[3];
  int    mc;
  int    checks = 0;
  int    errors = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_next(input int qv, input int maxv, input bit c,
                                    input bit l, input bit p, input bit t, input int d);
    if (!c) return 0;
    if (!l) return d;
    if (p && t) return (qv >= maxv) ? 0 : qv + 1;
    return qv;
  endfunction

  task automatic apply_model(input string tag);
    item_t it;
    m[0] = model_next(m[0], 15, clr_n, load_n, enp, ent, int'(din));
    m[1] = model_next(m[1], 9, clr_n, load_n, enp, ent, int'(din));
    m[2] = model_next(m[2], 15, clr_n, load_n, enp, ent, int'(din));
    mc   = model_next(mc, 4095, clr_n, cload_n, cen, cen, int'(cdin));
    it.tag = {tag, " [bin]"};  it.unit = 0; it.exp_q = m[0]; it.exp_tc = ent && (m[0] == 15); sbq.push_back(it);
    it.tag = {tag, " [dec]"};  it.unit = 1; it.exp_q = m[1]; it.exp_tc = ent && (m[1] == 9);  sbq.push_back(it);
    it.tag = {tag, " [asy]"};  it.unit = 2; it.exp_q = m[2]; it.exp_tc = ent && (m[2] == 15); sbq.push_back(it);
    it.tag = {tag, " [R10 chain]"}; it.unit = 3; it.exp_q = mc; it.exp_tc = cen && (mc == 4095); sbq.push_back(it);
  endtask

  task automatic drive(input bit c, input bit l, input bit p, input bit t, input logic [3:0] d,
                       input bit ce, input bit cl, input logic [11:0] cd, input string tag);
    @(negedge clk);
    clr_n = c; load_n = l; enp = p; ent = t; din = d;
    cen = ce; cload_n = cl; cdin = cd;
    apply_model(tag);
  endtask

  // monitor: compare queued expectations shortly after each rising edge
  initial begin
    item_t it;
    int aq;
    bit atc;
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        case (it.unit)
          0:       begin aq = int'(q_bin); atc = tc_bin; end
          1:       begin aq = int'(q_dec); atc = tc_dec; end
          2:       begin aq = int'(q_asy); atc = tc_asy; end
          default: begin aq = int'(cq);    atc = ctc[2]; end
        endcase
        check({it.tag, " state"}, aq, it.exp_q);
        check({it.tag, " R7 term"}, int'(atc), int'(it.exp_tc));
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m = '{0, 0, 0};
    mc = 0;
    // R1 R6: clear with load low and both enables high
    drive(0, 0, 1, 1, 4'd5, 1, 0, 12'd7, "R1 R6 clear wins");
    drive(0, 0, 1, 1, 4'd5, 1, 0, 12'd7, "R1 R6 clear wins");
    // R3: load with both enables low
    drive(1, 0, 0, 0, 4'd3, 0, 0, 12'hFFD, "R3 load enables low");
    // R4 R8 R10: counting, cascade crosses its full wrap
    for (int i = 0; i < 20; i++) drive(1, 1, 1, 1, 4'd0, 1, 1, 12'd0, "R4 R8 count");
    // R5: hold with either enable low
    drive(1, 1, 0, 1, 4'd0, 0, 1, 12'd0, "R5 hold cnt_en low");
    drive(1, 1, 0, 1, 4'd0, 0, 1, 12'd0, "R5 hold cnt_en low");
    drive(1, 1, 1, 0, 4'd0, 0, 1, 12'd0, "R5 hold chain_en low");
    drive(1, 1, 1, 0, 4'd0, 0, 1, 12'd0, "R5 hold chain_en low");
    // R7: term independent of cnt_en
    drive(1, 0, 1, 1, 4'd9, 0, 0, 12'h0EE, "R3 load nine");
    drive(1, 1, 0, 1, 4'd0, 0, 1, 12'd0, "R7 term with cnt_en low");
    drive(1, 1, 0, 0, 4'd0, 0, 1, 12'd0, "R7 term with chain_en low");
    drive(1, 0, 0, 1, 4'd15, 0, 1, 12'd0, "R3 load fifteen");
    drive(1, 1, 0, 1, 4'd0, 0, 1, 12'd0, "R7 term at binary top");
    drive(1, 1, 1, 1, 4'd0, 1, 1, 12'd0, "R4 binary wrap");
    // R9: every out-of-range decade state recovers in one count
    for (int d = 10; d < 16; d++) begin
      drive(1, 0, 1, 1, 4'(d), 1, 1, 12'd0, "R3 load out-of-range");
      drive(1, 1, 1, 1, 4'd0, 1, 1, 12'd0, "R9 recovery count");
    end
    // R10: cascade counting across nibble carries
    for (int i = 0; i < 30; i++) drive(1, 1, 0, 0, 4'd0, 1, 1, 12'd0, "R10 chain count");
    // R2: immediate clear on the async variant, sync variant waits
    drive(1, 0, 0, 0, 4'd7, 0, 1, 12'd0, "R3 load seven");
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b1; enp = 1'b1; ent = 1'b1;
    #1;
    check("R2 async clear without edge", int'(q_asy), 0);
    check("R1 sync clear waits for edge", int'(q_bin), m[0]);
    apply_model("R1 R2 clear edge");
    drive(1, 1, 1, 1, 4'd0, 1, 1, 12'd0, "R4 count after clear");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule